// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Bank with Two Interrupt Lines

This block is a bank of 32 general-purpose pins that a processor reaches through a 32-bit register bus. Each pin can be an input or a driven output. An input pin can report a rising edge, a falling edge, a low level or a high level.

Every detected event sets the pin's bit in two separate status registers. Each status register has its own enable register and its own interrupt line, so two consumers can each take a share of the pins. A wake request output lets an idle system be woken by chosen pins.

Set and clear alias addresses let software change single bits of the enables, the wake enables and the output data without a read-modify-write. Byte and halfword accesses are supported. Sub-word writes to an ordinary register keep the bytes they do not touch. Pin inputs pass through a two-flop synchronizer before any detection takes place.

Top module: `gpbank_top`

## Requirements
- R1: After reset, the direction register (0x34) reads all ones, pin_oe and pin_out are zero, and both status registers, both enables and the wake enable read zero. Both interrupt lines are low. The control register (0x30) reads 2, offset 0x14 reads 1 and offset 0x00 reads the revision parameter (default 0x25).
- R2: On an input pin, a rising edge is detected when enabled in 0x48 and a falling edge when enabled in 0x4C. Either one sets that pin's bit in both status 0x18 and status 0x28. An edge of the other polarity sets nothing.
- R3: While an input pin stays at a level enabled in 0x44 (high) or 0x40 (low), its status bits are set every cycle. This applies right after the level register is written, and a write-1 clear does not remove the bit while the level persists.
- R4: A pin whose bit in 0x34 is 0 is an output and raises no event.
- R5: irq_a is high exactly when status 0x18 ANDed with enable 0x1C is nonzero. irq_b works the same way for status 0x28 and enable 0x2C. The two lines are independent.
- R6: Writing a 1 to a bit of a status register clears that bit; a 0 leaves it. A clear of one status register leaves the other untouched. An event in the same cycle wins over the clear.
- R7: Alias pairs (clear, set) are 0x60/0x64 for enable 1, 0x70/0x74 for enable 2, 0x80/0x84 for wake enable 0x20, and 0x90/0x94 for output data 0x3C. Clear does AND-NOT and set does OR. Reading an alias returns the base register.
- R8: pin_out equals output data 0x3C. pin_oe is the inverse of direction 0x34.
- R9: Config 0x10 stores the written value ANDed with 0x1D. A written bit 1 resets every register except output data to its reset value, and the config register then keeps the masked value.
- R10: wake_o rises one cycle after an event on a pin whose wake-enable bit is set, provided config bit 2 is 1 and config bits 4:3 are nonzero. Otherwise it stays low.
- R11: bus_size selects the access width: 0 is byte, 1 is halfword, 2 is word. The data sits in the low bits of bus_wdata and is shifted left by 8 times bus_addr[1:0]. A sub-word write to an ordinary register keeps the other bytes. For status and alias registers, the shifted value is used alone, with zeros elsewhere.
- R12: A read returns the addressed register shifted right by 8 times bus_addr[1:0], with no masking of the upper bits.
- R13: Writes to 0x00, 0x14 and 0x38 have no effect; 0x38 reads the synchronized pins. Debounce enable 0x50 (32 bits) and debounce time 0x54 (8 bits) are plain read/write storage. Control 0x30 keeps 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to the pins |
| pin_oe | output | 32 | Drive enable per pin, 1 = driven |
| irq_a | output | 1 | Interrupt line 1 |
| irq_b | output | 1 | Interrupt line 2 |
| wake_o | output | 1 | Wake request |

## Verification
A corrupted status or enable bit appears on irq_a or irq_b in the same cycle it is stored, and it can be read from its register at once. A detection fault appears three clock edges after a pin toggles: two synchronizer stages plus the status register. A lane-merging error only surfaces when a later read or pin_out shows bytes that should have been kept. The bench therefore follows each sub-word write with a full-width observation. A wrong wake gate shows on wake_o one cycle after the config or wake-enable write.

// File: rtl/gpbank_pkg.sv
package gpbank_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_sz_e;

  localparam logic [ADDR_W-1:0] OFS_REV     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_HEALTH  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_ST_A    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EN_A    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WEN     = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ST_B    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_EN_B    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_CTL     = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_PINS    = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_LVL_LO  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_LVL_HI  = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_RISE    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_FALL    = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_DB_EN   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_DB_TM   = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_EN_A_C  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_EN_A_S  = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_EN_B_C  = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_EN_B_S  = 8'h74;
  localparam logic [ADDR_W-1:0] OFS_WEN_C   = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_WEN_S   = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_DOUT_C  = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_DOUT_S  = 8'h94;

  localparam int CFG_W = 5;
  localparam int CTL_W = 3;
  localparam int DBT_W = 8;
  localparam logic [CFG_W-1:0] CFG_KEEP  = 5'h1D;
  localparam logic [CTL_W-1:0] CTL_RST   = 3'd2;
  localparam int CFG_SRST_BIT  = 1;
  localparam int CFG_WAKE_BIT  = 2;
  localparam int CFG_IDLE_LSB  = 3;
endpackage

// File: rtl/gpbank_rst_sync.sv
module gpbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpbank_sync.sv
module gpbank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] smp_out,
  output logic [W-1:0] prv_out
);
  logic [W-1:0] meta_q, smp_q, prv_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        smp_q[g]  <= 1'b0;
        prv_q[g]  <= 1'b0;
      end else begin
        meta_q[g] <= async_in[g];
        smp_q[g]  <= meta_q[g];
        prv_q[g]  <= smp_q[g];
      end
    end
  end

  assign smp_out = smp_q;
  assign prv_out = prv_q;
endmodule

// File: rtl/gpbank_detect.sv
module gpbank_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] smp,
  input  logic [W-1:0] prv,
  input  logic [W-1:0] is_input,
  input  logic [W-1:0] lvl_lo,
  input  logic [W-1:0] lvl_hi,
  input  logic [W-1:0] on_rise,
  input  logic [W-1:0] on_fall,
  output logic [W-1:0] evt
);
  logic [W-1:0] edge_hit, level_hit;

  always_comb begin
    edge_hit  = (on_rise & smp & ~prv) | (on_fall & ~smp & prv);
    level_hit = (lvl_hi & smp) | (lvl_lo & ~smp);
    evt       = is_input & (edge_hit | level_hit);
  end
endmodule

// File: rtl/gpbank_lanes.sv
module gpbank_lanes
  import gpbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [1:0]    byte_sel,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] lane_mask,
  output logic [DW-1:0] wval,
  output logic [DW-1:0] rdata
);
  localparam int SW = $clog2(DW);

  logic [DW-1:0] base;
  logic [SW-1:0] shamt;

  always_comb begin
    case (size)
      SZ_BYTE: base = DW'(8'hFF);
      SZ_HALF: base = DW'(16'hFFFF);
      default: base = '1;
    endcase
    shamt     = (size == SZ_WORD) ? '0 : SW'({byte_sel, 3'b000});
    lane_mask = base << shamt;
    wval      = (wdata & base) << shamt;
    rdata     = rd_word >> SW'({byte_sel, 3'b000});
  end
endmodule

// File: rtl/gpbank_top.sv
module gpbank_top
  import gpbank_pkg::*;
#(
  parameter int          DW     = 32,
  parameter logic [31:0] REV_ID = 32'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pin_in,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     pin_oe,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_o
);
  logic rst_q_n;
  logic [DW-1:0] pin_s, pin_p, evt;
  logic [DW-1:0] lane_mask, wval, rd_word;
  logic [ADDR_W-1:0] word_ofs;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [DBT_W-1:0] dbt_q, dbt_d;
  logic [DW-1:0] dir_q, dir_d, dout_q, dout_d;
  logic [DW-1:0] st_a_q, st_a_d, st_b_q, st_b_d;
  logic [DW-1:0] en_a_q, en_a_d, en_b_q, en_b_d, wen_q, wen_d;
  logic [DW-1:0] lo_q, lo_d, hi_q, hi_d, rise_q, rise_d, fall_q, fall_d;
  logic [DW-1:0] dben_q, dben_d;
  logic          wake_q, wake_d;
  logic [DW-1:0] clr_a, clr_b, cfg_wr;
  logic          soft_hit, clr_a_hit;

  function automatic logic [DW-1:0] f_merge(input logic [DW-1:0] cur,
                                            input logic [DW-1:0] m,
                                            input logic [DW-1:0] v);
    return (cur & ~m) | (v & m);
  endfunction

  gpbank_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  gpbank_sync #(.W(DW)) i_sync (
    .clk(clk), .rst_n(rst_q_n), .async_in(pin_in),
    .smp_out(pin_s), .prv_out(pin_p)
  );

  gpbank_detect #(.W(DW)) i_det (
    .smp(pin_s), .prv(pin_p), .is_input(dir_q),
    .lvl_lo(lo_q), .lvl_hi(hi_q), .on_rise(rise_q), .on_fall(fall_q),
    .evt(evt)
  );

  gpbank_lanes #(.DW(DW)) i_lanes (
    .byte_sel(bus_addr[1:0]), .size(bus_size), .wdata(bus_wdata),
    .rd_word(rd_word), .lane_mask(lane_mask), .wval(wval),
    .rdata(bus_rdata)
  );

  assign word_ofs  = {bus_addr[ADDR_W-1:2], 2'b00};
  assign cfg_wr    = f_merge(DW'(cfg_q), lane_mask, wval);
  assign soft_hit  = bus_we && (word_ofs == OFS_CFG) && cfg_wr[CFG_SRST_BIT];
  assign clr_a_hit = bus_we && (word_ofs == OFS_ST_A);

  // Read multiplexer: aliases return their base register
  always_comb begin
    case (word_ofs)
      OFS_REV:                         rd_word = DW'(REV_ID);
      OFS_CFG:                         rd_word = DW'(cfg_q);
      OFS_HEALTH:                      rd_word = DW'(1);
      OFS_ST_A:                        rd_word = st_a_q;
      OFS_EN_A, OFS_EN_A_C, OFS_EN_A_S: rd_word = en_a_q;
      OFS_WEN, OFS_WEN_C, OFS_WEN_S:   rd_word = wen_q;
      OFS_ST_B:                        rd_word = st_b_q;
      OFS_EN_B, OFS_EN_B_C, OFS_EN_B_S: rd_word = en_b_q;
      OFS_CTL:                         rd_word = DW'(ctl_q);
      OFS_DIR:                         rd_word = dir_q;
      OFS_PINS:                        rd_word = pin_s;
      OFS_DOUT, OFS_DOUT_C, OFS_DOUT_S: rd_word = dout_q;
      OFS_LVL_LO:                      rd_word = lo_q;
      OFS_LVL_HI:                      rd_word = hi_q;
      OFS_RISE:                        rd_word = rise_q;
      OFS_FALL:                        rd_word = fall_q;
      OFS_DB_EN:                       rd_word = dben_q;
      OFS_DB_TM:                       rd_word = DW'(dbt_q);
      default:                         rd_word = '0;
    endcase
  end

  // Next-state logic
  always_comb begin
    cfg_d = cfg_q;   ctl_d = ctl_q;   dbt_d = dbt_q;
    dir_d = dir_q;   dout_d = dout_q;
    en_a_d = en_a_q; en_b_d = en_b_q; wen_d = wen_q;
    lo_d = lo_q;     hi_d = hi_q;     rise_d = rise_q; fall_d = fall_q;
    dben_d = dben_q;
    clr_a = '0;      clr_b = '0;

    if (bus_we) begin
      case (word_ofs)
        OFS_CFG:    cfg_d  = cfg_wr[CFG_W-1:0] & CFG_KEEP;
        OFS_ST_A:   clr_a  = wval;
        OFS_ST_B:   clr_b  = wval;
        OFS_EN_A:   en_a_d = f_merge(en_a_q, lane_mask, wval);
        OFS_EN_A_C: en_a_d = en_a_q & ~wval;
        OFS_EN_A_S: en_a_d = en_a_q | wval;
        OFS_EN_B:   en_b_d = f_merge(en_b_q, lane_mask, wval);
        OFS_EN_B_C: en_b_d = en_b_q & ~wval;
        OFS_EN_B_S: en_b_d = en_b_q | wval;
        OFS_WEN:    wen_d  = f_merge(wen_q, lane_mask, wval);
        OFS_WEN_C:  wen_d  = wen_q & ~wval;
        OFS_WEN_S:  wen_d  = wen_q | wval;
        OFS_DOUT:   dout_d = f_merge(dout_q, lane_mask, wval);
        OFS_DOUT_C: dout_d = dout_q & ~wval;
        OFS_DOUT_S: dout_d = dout_q | wval;
        OFS_DIR:    dir_d  = f_merge(dir_q, lane_mask, wval);
        OFS_LVL_LO: lo_d   = f_merge(lo_q, lane_mask, wval);
        OFS_LVL_HI: hi_d   = f_merge(hi_q, lane_mask, wval);
        OFS_RISE:   rise_d = f_merge(rise_q, lane_mask, wval);
        OFS_FALL:   fall_d = f_merge(fall_q, lane_mask, wval);
        OFS_DB_EN:  dben_d = f_merge(dben_q, lane_mask, wval);
        OFS_DB_TM:  dbt_d  = DBT_W'(f_merge(DW'(dbt_q), lane_mask, wval));
        OFS_CTL:    ctl_d  = CTL_W'(f_merge(DW'(ctl_q), lane_mask, wval));
        default:    ;
      endcase
    end

    // events win over a same-cycle clear
    st_a_d = (st_a_q & ~clr_a) | evt;
    st_b_d = (st_b_q & ~clr_b) | evt;
    wake_d = cfg_q[CFG_WAKE_BIT] && (cfg_q[CFG_IDLE_LSB+:2] != 2'b00) &&
             ((evt & wen_q) != '0);

    if (soft_hit) begin
      cfg_d  = cfg_wr[CFG_W-1:0] & CFG_KEEP;
      ctl_d  = CTL_RST;
      dbt_d  = '0;
      dir_d  = '1;
      en_a_d = '0;  en_b_d = '0;  wen_d = '0;
      st_a_d = '0;  st_b_d = '0;
      lo_d   = '0;  hi_d = '0;    rise_d = '0;  fall_d = '0;
      dben_d = '0;
      wake_d = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cfg_q  <= '0;       ctl_q  <= CTL_RST;  dbt_q <= '0;
      dir_q  <= '1;       dout_q <= '0;
      en_a_q <= '0;       en_b_q <= '0;       wen_q <= '0;
      st_a_q <= '0;       st_b_q <= '0;
      lo_q   <= '0;       hi_q   <= '0;       rise_q <= '0;  fall_q <= '0;
      dben_q <= '0;       wake_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;    ctl_q  <= ctl_d;    dbt_q <= dbt_d;
      dir_q  <= dir_d;    dout_q <= dout_d;
      en_a_q <= en_a_d;   en_b_q <= en_b_d;   wen_q <= wen_d;
      st_a_q <= st_a_d;   st_b_q <= st_b_d;
      lo_q   <= lo_d;     hi_q   <= hi_d;     rise_q <= rise_d;  fall_q <= fall_d;
      dben_q <= dben_d;   wake_q <= wake_d;
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = ~dir_q;
  assign irq_a   = (st_a_q & en_a_q) != '0;
  assign irq_b   = (st_b_q & en_b_q) != '0;
  assign wake_o  = wake_q;
endmodule

// File: rtl/gpbank_chk.sv
module gpbank_chk
  import gpbank_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DW-1:0]    st_a,
  input logic [DW-1:0]    st_b,
  input logic [DW-1:0]    dir,
  input logic [CFG_W-1:0] cfg,
  input logic             wake,
  input logic             clr_a_hit,
  input logic             soft_hit
);
  // R6: a status-1 bit only drops after a clear write or a soft reset
  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_a) & ~st_a) != '0) |-> ($past(clr_a_hit) || $past(soft_hit)));

  // R2: any bit newly set in status 1 is also set in status 2
  assert_dual_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_a & ~$past(st_a) & ~st_b) == '0));

  // R4: output pins never raise a new status bit
  assert_inputs_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_a & ~$past(st_a) & ~$past(dir)) == '0));

  // R10: wake only when enabled and an idle mode is selected
  assert_wake_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(cfg[CFG_WAKE_BIT]) && ($past(cfg[CFG_IDLE_LSB+:2]) != 2'b00)));

  // R9: soft reset restores direction and clears both status registers
  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_hit) |-> ((dir == '1) && (st_a == '0) && (st_b == '0)));
endmodule

bind gpbank_top gpbank_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_q_n), .st_a(st_a_q), .st_b(st_b_q), .dir(dir_q),
  .cfg(cfg_q), .wake(wake_q), .clr_a_hit(clr_a_hit), .soft_hit(soft_hit)
);

// File: tb/test_gpbank_top.sv
module test_gpbank_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic [31:0] pin_in = '0;
  logic        irq_a, irq_b, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int          kq[$];
  logic [31:0] eq[$];
  string       tq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpbank_top i_gpbank_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_a(irq_a), .irq_b(irq_b), .wake_o(wake_o)
  );

  // kinds: 0 read data, 1 irq_a, 2 irq_b, 3 wake_o, 4 pin_out, 5 pin_oe
  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a; bus_size = sz;
    kq.push_back(0); eq.push_back(e); tq.push_back(t);
  endtask

  task automatic exp_port(input int k, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    kq.push_back(k); eq.push_back(e); tq.push_back(t);
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(posedge clk); #1;
    pin_in = v;
    repeat (4) @(posedge clk);
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (kq.size() > 0) begin
      int          k;
      logic [31:0] e, act;
      string       t;
      k = kq.pop_front(); e = eq.pop_front(); t = tq.pop_front();
      case (k)
        0:       act = bus_rdata;
        1:       act = {31'b0, irq_a};
        2:       act = {31'b0, irq_b};
        3:       act = {31'b0, wake_o};
        4:       act = pin_out;
        default: act = pin_oe;
      endcase
      n_chk++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, act, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    exp_rd(8'h34, 2'd2, 32'hFFFFFFFF, "R1 dir");
    exp_rd(8'h30, 2'd2, 32'h2, "R1 ctl");
    exp_rd(8'h14, 2'd2, 32'h1, "R1 health");
    exp_rd(8'h00, 2'd2, 32'h25, "R1 rev");
    exp_rd(8'h18, 2'd2, 32'h0, "R1 status");
    exp_rd(8'h1C, 2'd2, 32'h0, "R1 enable");
    exp_port(1, 32'h0, "R1 irq_a");
    exp_port(5, 32'h0, "R1 pin_oe");
    exp_port(4, 32'h0, "R1 pin_out");

    // R8 outputs
    wr(8'h34, 2'd2, 32'hFFFF0000);
    wr(8'h3C, 2'd2, 32'h1234ABCD);
    exp_port(4, 32'h1234ABCD, "R8 pin_out");
    exp_port(5, 32'h0000FFFF, "R8 pin_oe");

    // R7 aliases
    wr(8'h94, 2'd2, 32'h00F00000);
    wr(8'h90, 2'd2, 32'h0000000D);
    exp_rd(8'h94, 2'd2, 32'h12F4ABC0, "R7 dout alias");
    wr(8'h64, 2'd2, 32'h000000F0);
    wr(8'h60, 2'd2, 32'h00000030);
    exp_rd(8'h1C, 2'd2, 32'h000000C0, "R7 en1");
    wr(8'h74, 2'd2, 32'h0F0F0000);
    wr(8'h70, 2'd2, 32'h0F000000);
    exp_rd(8'h2C, 2'd2, 32'h000F0000, "R7 en2");
    wr(8'h84, 2'd2, 32'h00010000);
    exp_rd(8'h80, 2'd2, 32'h00010000, "R7 wen alias");

    // R2 edges
    wr(8'h48, 2'd2, 32'h00010000);
    wr(8'h4C, 2'd2, 32'h00020000);
    drive_pins(32'h00010000);
    exp_rd(8'h18, 2'd2, 32'h00010000, "R2 rise st1");
    exp_rd(8'h28, 2'd2, 32'h00010000, "R2 rise st2");
    exp_port(1, 32'h0, "R5 irq_a masked");
    exp_port(2, 32'h1, "R5 irq_b");
    drive_pins(32'h00030000);
    exp_rd(8'h18, 2'd2, 32'h00010000, "R2 wrong polarity");
    drive_pins(32'h00010000);
    exp_rd(8'h18, 2'd2, 32'h00030000, "R2 fall st1");

    // R6 write-1-to-clear
    wr(8'h18, 2'd2, 32'h00010000);
    exp_rd(8'h18, 2'd2, 32'h00020000, "R6 clear st1");
    exp_rd(8'h28, 2'd2, 32'h00030000, "R6 st2 kept");
    exp_port(2, 32'h1, "R6 irq_b still");
    wr(8'h28, 2'd2, 32'h00030000);
    exp_port(2, 32'h0, "R6 irq_b cleared");

    // R4 output pin ignores edge
    wr(8'h48, 2'd2, 32'h00010001);
    drive_pins(32'h00010001);
    exp_rd(8'h18, 2'd2, 32'h00020000, "R4 output pin");

    // R3 levels
    wr(8'h44, 2'd2, 32'h00040000);
    drive_pins(32'h00050001);
    exp_rd(8'h18, 2'd2, 32'h00060000, "R3 high level");
    wr(8'h18, 2'd2, 32'h00040000);
    exp_rd(8'h18, 2'd2, 32'h00060000, "R3 reasserted");
    drive_pins(32'h00010001);
    wr(8'h18, 2'd2, 32'h00040000);
    exp_rd(8'h18, 2'd2, 32'h00020000, "R3 level gone");
    wr(8'h40, 2'd2, 32'h00080000);
    exp_rd(8'h18, 2'd2, 32'h000A0000, "R3 low level on write");
    wr(8'h40, 2'd2, 32'h0);
    wr(8'h18, 2'd2, 32'h00080000);
    exp_rd(8'h18, 2'd2, 32'h00020000, "R3 low cleared");

    // R9 config mask, R10 wake
    wr(8'h10, 2'd2, 32'h0000002D);
    exp_rd(8'h10, 2'd2, 32'h0000000D, "R9 cfg mask");
    exp_port(3, 32'h0, "R10 no event");
    wr(8'h44, 2'd2, 32'h00050000);
    exp_port(3, 32'h1, "R10 wake");
    wr(8'h10, 2'd2, 32'h00000004);
    exp_port(3, 32'h0, "R10 idle zero");
    wr(8'h10, 2'd2, 32'h0000000C);
    exp_port(3, 32'h1, "R10 wake again");
    wr(8'h80, 2'd2, 32'h00010000);
    exp_port(3, 32'h0, "R10 wen cleared");

    // R11 sub-word writes
    wr(8'h3D, 2'd0, 32'h0000005A);
    exp_port(4, 32'h12F45AC0, "R11 byte merge");
    wr(8'h3E, 2'd1, 32'h0000BEEF);
    exp_port(4, 32'hBEEF5AC0, "R11 half merge");
    wr(8'h66, 2'd0, 32'h00000001);
    wr(8'h61, 2'd0, 32'h000000FF);
    exp_rd(8'h1C, 2'd2, 32'h000100C0, "R11 alias lone value");
    exp_port(1, 32'h1, "R5 irq_a");

    // R12 sub-word reads
    exp_rd(8'h3E, 2'd1, 32'h0000BEEF, "R12 half read");
    exp_rd(8'h3D, 2'd0, 32'h00BEEF5A, "R12 byte read");

    // R13 read-only and storage
    wr(8'h38, 2'd2, 32'h0);
    exp_rd(8'h38, 2'd2, 32'h00010001, "R13 pins read-only");
    wr(8'h00, 2'd2, 32'h0);
    exp_rd(8'h00, 2'd2, 32'h25, "R13 rev read-only");
    wr(8'h50, 2'd2, 32'hA5A5A5A5);
    exp_rd(8'h50, 2'd2, 32'hA5A5A5A5, "R13 debounce en");
    wr(8'h54, 2'd2, 32'h000001FF);
    exp_rd(8'h54, 2'd2, 32'h000000FF, "R13 debounce time");
    wr(8'h30, 2'd2, 32'h0000000F);
    exp_rd(8'h30, 2'd2, 32'h7, "R13 ctl width");

    // R9 soft reset
    wr(8'h10, 2'd2, 32'h00000002);
    exp_rd(8'h34, 2'd2, 32'hFFFFFFFF, "R9 dir reset");
    exp_rd(8'h1C, 2'd2, 32'h0, "R9 en1 reset");
    exp_rd(8'h18, 2'd2, 32'h0, "R9 st1 reset");
    exp_rd(8'h30, 2'd2, 32'h2, "R9 ctl reset");
    exp_rd(8'h10, 2'd2, 32'h0, "R9 cfg masked");
    exp_port(4, 32'hBEEF5AC0, "R9 dout kept");
    exp_port(1, 32'h0, "R9 irq_a low");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule